// File: doc/BRIEF.md
# Link Startup Latency Meter

This block measures how many link clock cycles pass between the moment a receiver releases its active-low synchronisation request and the moment the receiver first reports valid user data. A measurement starts when the request line goes from low to high. It ends at the first cycle in which the link-valid input is seen high. The count is then held in a result register, and a done flag is raised.

Each new measurement is compared with the result of the run before it. This shows whether the startup latency stays the same from one link restart to the next. A mismatch flag reports any difference. The very first result after a block reset has nothing to compare against, so that run never flags a mismatch. The counter stops at its largest value rather than wrapping, and it raises an overflow flag when it gets there.

The block is meant to be placed beside a multi-lane receiver during bring-up or in a production self-test. A link restart is made by driving the request low again. After each restart the three result outputs are read once `lat_done` is high.

Top module: `link_lat_meter`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `lat_count` is 0 and `lat_done`, `lat_mismatch` and `lat_overflow` are all 0.
- R2: A start event happens at a clock edge where `sync_n` is sampled high and was sampled low at the edge before. `rst` leaves the stored previous sample at 1, so `sync_n` already high when reset is released is not a start. A start clears `lat_done` at that same edge.
- R3: The result is N, where the start edge is edge k and edge k+N is the first edge after k at which `link_valid` is sampled high. It is latched into `lat_count`, and `lat_done` rises at edge k+N. The smallest result is 1, and this includes the case where `link_valid` is already high at the start edge.
- R4: After a result is latched, any further change on `link_valid` leaves `lat_count`, `lat_done`, `lat_mismatch` and `lat_overflow` unchanged until the next start event.
- R5: If `sync_n` is sampled low while a measurement is running, the measurement ends with no result. `lat_done` stays 0, `lat_count` keeps its old value, and the next start counts from zero again.
- R6: The counter saturates at 2^CNT_W-1. `lat_overflow` becomes 1 at the edge where the running count reaches that value and is cleared by the next start. A result that saturated reads exactly 2^CNT_W-1.
- R7: On the first result after reset, `lat_mismatch` is 0.
- R8: On every later result, `lat_mismatch` is set to 1 if the new count differs from the result held before it and to 0 if it is equal. It changes only at the edge where a result is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Active-low synchronisation request; a rising edge starts a measurement |
| link_valid | input | 1 | Receiver reports valid user data; first high level stops the measurement |
| lat_count | output | CNT_W | Latched latency in link clock cycles |
| lat_done | output | 1 | Result valid, held until the next start |
| lat_mismatch | output | 1 | Latest result differs from the one before it |
| lat_overflow | output | 1 | Counter reached its saturation value in the current or last run |

## Verification
The stop event and saturation can happen in the same cycle. This occurs when `link_valid` first rises exactly when the running count reaches 2^CNT_W-1. The bench uses a 6-bit counter so it can reach that point: a run of length 63 must give a result of 63 with the overflow flag set, and a run of 62 must give 62 with the flag clear. A second coincidence is a start event with `link_valid` already high. That run must give the minimum result of 1 and must not stop at the start edge itself.

// File: rtl/lat_meter_pkg.sv
package lat_meter_pkg;

    // Measurement phase of the meter.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // waiting for a start, no result held
        PH_RUN  = 2'd1,   // counting link clocks
        PH_HOLD = 2'd2    // result latched, done presented
    } phase_e;

    // Events decoded from the inputs in one cycle.
    typedef struct packed {
        logic start;   // request line rose
        logic abort;   // request line dropped during a run
        logic stop;    // first valid seen during a run
    } meter_evt_t;

    // Next phase from the current phase and the decoded events.
    function automatic phase_e next_phase(phase_e cur, meter_evt_t ev);
        phase_e nxt;
        nxt = cur;
        case (cur)
            PH_IDLE: if (ev.start) nxt = PH_RUN;
            PH_RUN: begin
                if (ev.abort)     nxt = PH_IDLE;
                else if (ev.stop) nxt = PH_HOLD;
            end
            PH_HOLD: if (ev.start) nxt = PH_RUN;
            default: nxt = PH_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/lat_edge_detect.sv
module lat_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic rise
);
    logic sig_q;

    // Reset to high so a line already released at reset is no start.
    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b1;
        else     sig_q <= sig_in;
    end

    assign rise = sig_in & ~sig_q;
endmodule

// File: rtl/lat_sat_counter.sv
module lat_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] cnt_inc,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;

    assign cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (en) begin
            cnt <= cnt_inc;
            if (cnt_inc == CNT_MAX) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/lat_result_store.sv
module lat_result_store #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] new_val,
    output logic [CNT_W-1:0] result,
    output logic             mismatch
);
    logic have_prev;

    // The held result is also the reference for the next comparison.
    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            mismatch  <= 1'b0;
            have_prev <= 1'b0;
        end else if (load) begin
            result    <= new_val;
            mismatch  <= have_prev && (new_val != result);
            have_prev <= 1'b1;
        end
    end
endmodule

// File: rtl/link_lat_meter.sv
module link_lat_meter
    import lat_meter_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_n,
    input  logic             link_valid,
    output logic [CNT_W-1:0] lat_count,
    output logic             lat_done,
    output logic             lat_mismatch,
    output logic             lat_overflow
);
    phase_e           phase;
    meter_evt_t       ev;
    logic             sync_rise;
    logic [CNT_W-1:0] cnt_inc;

    lat_edge_detect u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_in (sync_n),
        .rise   (sync_rise)
    );

    always_comb begin
        ev.start = sync_rise;
        ev.abort = (phase == PH_RUN) && !sync_n;
        ev.stop  = (phase == PH_RUN) && sync_n && link_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= next_phase(phase, ev);
    end

    lat_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (ev.start),
        .en      (phase == PH_RUN),
        .cnt_inc (cnt_inc),
        .ovf     (lat_overflow)
    );

    lat_result_store #(.CNT_W(CNT_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .load     (ev.stop),
        .new_val  (cnt_inc),
        .result   (lat_count),
        .mismatch (lat_mismatch)
    );

    assign lat_done = (phase == PH_HOLD);
endmodule

// File: rtl/lat_meter_checker.sv
module lat_meter_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             sync_n,
    input logic             link_valid,
    input logic [CNT_W-1:0] lat_count,
    input logic             lat_done,
    input logic             lat_mismatch,
    input logic             lat_overflow
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (lat_count == '0 && !lat_done && !lat_mismatch && !lat_overflow)); // R1

    AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $rose(lat_done) |-> $past(link_valid)); // R3

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (lat_done && !(sync_n && !$past(sync_n))) |=> lat_done); // R4

    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (rst || !past_ok)
        lat_done |=> $stable(lat_count)); // R4

    AST_NO_DONE_WHILE_LOW: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (!sync_n && !lat_done) |=> !lat_done); // R5

    AST_SATURATED_RESULT: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (lat_done && lat_overflow) |-> (lat_count == CNT_MAX)); // R6

    AST_MISMATCH_ON_RESULT: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !$rose(lat_done) |-> $stable(lat_mismatch)); // R8
endmodule

bind link_lat_meter lat_meter_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sync_n       (sync_n),
    .link_valid   (link_valid),
    .lat_count    (lat_count),
    .lat_done     (lat_done),
    .lat_mismatch (lat_mismatch),
    .lat_overflow (lat_overflow)
);

// File: tb/sim_link_lat_meter.sv
`timescale 1ns/1ps
module sim_link_lat_meter;
    localparam int BW = 6;
    localparam int MAXV = (1 << BW) - 1;

    typedef struct {
        int cnt;
        bit mm;
        bit ovf;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sync_n = 1'b0;
    logic          link_valid = 1'b0;
    logic [BW-1:0] lat_count;
    logic          lat_done, lat_mismatch, lat_overflow;

    int   checks = 0;
    int   errors = 0;
    exp_t sb_q[$];
    int   prev_res = 0;
    bit   have_prev = 0;
    bit   done_d = 0;

    always #2.5 clk = ~clk;

    link_lat_meter #(.CNT_W(BW)) u0 (
        .clk (clk), .rst (rst), .sync_n (sync_n), .link_valid (link_valid),
        .lat_count (lat_count), .lat_done (lat_done),
        .lat_mismatch (lat_mismatch), .lat_overflow (lat_overflow)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: restart the link and release valid n cycles after the start edge.
    task automatic run_lat(int n, bit early, string tag);
        exp_t e;
        int   r;
        link_valid = 1'b0;
        sync_n = 1'b0;
        repeat (3) @(negedge clk);
        r = (n > MAXV) ? MAXV : n;
        e.cnt = r;
        e.mm  = have_prev && (r != prev_res);
        e.ovf = (r == MAXV);
        e.tag = tag;
        sb_q.push_back(e);
        prev_res = r;
        have_prev = 1;
        sync_n = 1'b1;
        if (early) begin
            link_valid = 1'b1;
        end else begin
            for (int i = 0; i < n; i++) begin
                @(negedge clk);
                if (i == 0 && n > 1) check("R2 done cleared by start", lat_done, 0);
            end
            link_valid = 1'b1;
        end
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pop an expected item on each new result.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && lat_done && !done_d) begin
                if (sb_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R5 unexpected result: actual %0d expected none", lat_count);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check({"R3 count ", e.tag}, lat_count, e.cnt);
                    check({"R7/R8 mismatch ", e.tag}, lat_mismatch, e.mm);
                    check({"R6 overflow ", e.tag}, lat_overflow, e.ovf);
                end
            end
            done_d = lat_done;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int hold_cnt;
        repeat (4) @(negedge clk);
        check("R1 count at reset", lat_count, 0);
        check("R1 done at reset", lat_done, 0);
        check("R1 mismatch at reset", lat_mismatch, 0);
        check("R1 overflow at reset", lat_overflow, 0);
        sync_n = 1'b1;            // already released when reset ends
        @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        link_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 no start without low phase", lat_done, 0);

        run_lat(5, 0, "R7 first");
        run_lat(5, 0, "R8 equal");
        run_lat(7, 0, "R8 differ");
        run_lat(7, 0, "R8 equal again");
        run_lat(1, 1, "R3 valid already high");

        // R4: later toggles of valid are ignored
        hold_cnt = lat_count;
        for (int i = 0; i < 6; i++) begin
            link_valid = ~link_valid;
            @(negedge clk);
        end
        check("R4 count held", lat_count, hold_cnt);
        check("R4 done held", lat_done, 1);
        check("R4 mismatch held", lat_mismatch, 1);

        run_lat(62, 0, "R6 below max");
        run_lat(63, 0, "R6 reaches max");
        run_lat(80, 0, "R6 saturated");

        // R5: abort a run by asserting the request again
        link_valid = 1'b0;
        sync_n = 1'b0;
        repeat (3) @(negedge clk);
        sync_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R6 overflow cleared by start", lat_overflow, 0);
        sync_n = 1'b0;
        @(negedge clk);
        link_valid = 1'b1;
        repeat (4) @(negedge clk);
        check("R5 no done after abort", lat_done, 0);
        check("R5 count kept after abort", lat_count, MAXV);
        run_lat(10, 0, "R5 restart from zero");

        repeat (5) @(negedge clk);
        check("R3 all results seen", sb_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule